// File: doc/BRIEF.md
# Memory Error Capture Registers

This block sits next to a memory ECC checker and gives the processor a small register set for memory errors. When the checker reports an error, the block records three things: the failing address, the complemented syndrome, and the bank and error class. It then holds that record until software acknowledges it. An interrupt level is raised when the class of the held error (single or double) is enabled for reporting.

A control register decides whether the checker should correct single-bit errors, and whether each error class is reported. The report enables are active-low. An all-ones control word therefore means "correct, stay silent". Software acknowledges an error by writing the status register, with any value. That write wipes the record and arms the block for the next error. The ECC computation and the CPU bus decoding sit outside this block. Register access uses a plain select/write-enable port with a combinational read path.

Top module: `memerr_capture`

## Requirements
- R1: After reset the control register reads 16'hFFFF, the address and status registers read 0, `corrEnable` is 1 and `irq` is 0.
- R2: A write with `regSel`=2 stores all 16 bits of `regWrData` in the control register, which reads back unchanged. Control bit 1 (weight 2) drives `corrEnable` from the next cycle.
- R3: An error (`errValid`=1) while no error is held captures into the registers at the next clock edge. The address register gets `errAddr`, zero-extended. The status register gets the complement of `errSyndrome` in bits [7:2], `errDouble` in bit 9 (weight 8'o1000) and `errBank` in bits [1:0]. All other status bits read 0.
- R4: A write with `regSel`=1 clears the address and status registers to 0 and re-arms capture. If `errValid` is high in the same cycle, that error is captured instead.
- R5: While an error is held, further errors are ignored, and address and status keep their captured values.
- R6: `irq` is 1 exactly when an error is held and its class is enabled for reporting. Control bit 2 (weight 4) = 0 enables reporting of single errors (status bit 9 = 0). Control bit 3 (weight 8) = 0 enables reporting of double errors (status bit 9 = 1).
- R7: A control write changes `irq` from the next cycle without disturbing the held error. Writing a value that enables the held class raises `irq` again.
- R8: `regRdData` shows address, status, control or 0 for `regSel` = 0, 1, 2 or 3 respectively, in the same cycle.
- R9: Writes with `regSel`=0 or `regSel`=3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | Error detected by the ECC checker this cycle |
| errAddr | input | AddrW | Address of the failing access |
| errSyndrome | input | 6 | True syndrome from the checker |
| errDouble | input | 1 | Error is uncorrectable (double) |
| errBank | input | 2 | Bank of the failing access |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 address, 1 status, 2 control, 3 none |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register |
| corrEnable | output | 1 | Correction enable to the ECC checker |
| irq | output | 1 | Error interrupt level |

## Verification
The bench aims at four corner cases:
- An error that arrives in the same cycle as the status write. A design that gives the clear priority would lose that error and read zeros.
- A second error while one is held. A design that re-captures would show the later address and syndrome.
- Report-enable polarity. Inverting it would interrupt on an all-ones control word and stay silent on 16'hFFF3.
- The class gating of `irq` by the stored double flag. Using the wrong enable bit would show up when single and double reporting are set differently.

Syndrome complementing and field placement are checked through exact status values. Long mixed sequences are compared against a behavioural model on every cycle.

// File: rtl/memerr_pkg.sv
package memerr_pkg;

  localparam int REG_W = 16;
  localparam int SYN_W = 6;
  localparam int BANK_W = 2;

  // status field placement (LSB-0 numbering)
  localparam int STAT_BANK_LO = 0;
  localparam int STAT_SYN_LO  = 2;
  localparam int STAT_DBL_BIT = 9;

  // control bit placement
  localparam int CTRL_CORR_BIT   = 1;
  localparam int CTRL_SGL_OFF_BIT = 2;
  localparam int CTRL_DBL_OFF_BIT = 3;
  localparam logic [REG_W-1:0] CTRL_RESET = '1;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regsel_e;

  typedef struct packed {
    logic capture;
    logic clear;
    logic ctrlWr;
  } memerr_strobe_t;

endpackage

// File: rtl/memerr_ctrl.sv
module memerr_ctrl
  import memerr_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           errValid,
  input  logic           regWrEn,
  input  logic [1:0]     regSel,
  input  logic           heldDouble,
  input  logic           sglOffN,
  input  logic           dblOffN,
  output memerr_strobe_t strobe,
  output logic           pending,
  output logic           irq
);

  logic clearHit;
  logic ctrlHit;

  always_comb begin
    clearHit = regWrEn && (regSel == SEL_STAT);
    ctrlHit  = regWrEn && (regSel == SEL_CTRL);
    strobe.clear   = clearHit;
    strobe.ctrlWr  = ctrlHit;
    // a clear re-arms in the same cycle, so a coincident error is kept
    strobe.capture = errValid && (!pending || clearHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.capture) begin
      pending <= 1'b1;
    end else if (strobe.clear) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    if (heldDouble) begin
      irq = pending && !dblOffN;
    end else begin
      irq = pending && !sglOffN;
    end
  end

endmodule

// File: rtl/memerr_dp.sv
module memerr_dp
  import memerr_pkg::*;
#(
  parameter int AddrW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  memerr_strobe_t      strobe,
  input  logic [AddrW-1:0]    errAddr,
  input  logic [SYN_W-1:0]    errSyndrome,
  input  logic                errDouble,
  input  logic [BANK_W-1:0]   errBank,
  input  logic [1:0]          regSel,
  input  logic [REG_W-1:0]    regWrData,
  output logic [AddrW-1:0]    capAddr,
  output logic [REG_W-1:0]    capStatus,
  output logic [REG_W-1:0]    ctrlReg,
  output logic [REG_W-1:0]    regRdData
);

  localparam int PAD_W = REG_W - AddrW;

  logic [REG_W-1:0] statusNext;
  logic [REG_W-1:0] addrWide;

  always_comb begin
    statusNext = '0;
    statusNext[STAT_SYN_LO +: SYN_W]   = ~errSyndrome;
    statusNext[STAT_BANK_LO +: BANK_W] = errBank;
    statusNext[STAT_DBL_BIT]           = errDouble;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign addrWide = {{PAD_W{1'b0}}, capAddr};
    end else begin : g_nopad
      assign addrWide = capAddr[REG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr   <= '0;
      capStatus <= '0;
    end else if (strobe.capture) begin
      capAddr   <= errAddr;
      capStatus <= statusNext;
    end else if (strobe.clear) begin
      capAddr   <= '0;
      capStatus <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
    end else if (strobe.ctrlWr) begin
      ctrlReg <= regWrData;
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_ADDR: regRdData = addrWide;
      SEL_STAT: regRdData = capStatus;
      SEL_CTRL: regRdData = ctrlReg;
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/memerr_capture.sv
module memerr_capture
  import memerr_pkg::*;
#(
  parameter int AddrW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errValid,
  input  logic [AddrW-1:0]  errAddr,
  input  logic [5:0]        errSyndrome,
  input  logic              errDouble,
  input  logic [1:0]        errBank,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              corrEnable,
  output logic              irq
);

  memerr_strobe_t    strobe;
  logic              pending;
  logic [AddrW-1:0]  capAddr;
  logic [REG_W-1:0]  capStatus;
  logic [REG_W-1:0]  ctrlReg;

  memerr_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .errValid   (errValid),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .heldDouble (capStatus[STAT_DBL_BIT]),
    .sglOffN    (ctrlReg[CTRL_SGL_OFF_BIT]),
    .dblOffN    (ctrlReg[CTRL_DBL_OFF_BIT]),
    .strobe     (strobe),
    .pending    (pending),
    .irq        (irq)
  );

  memerr_dp #(.AddrW(AddrW)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .errAddr     (errAddr),
    .errSyndrome (errSyndrome),
    .errDouble   (errDouble),
    .errBank     (errBank),
    .regSel      (regSel),
    .regWrData   (regWrData),
    .capAddr     (capAddr),
    .capStatus   (capStatus),
    .ctrlReg     (ctrlReg),
    .regRdData   (regRdData)
  );

  assign corrEnable = ctrlReg[CTRL_CORR_BIT];

endmodule

// File: rtl/memerr_capture_chk.sv
module memerr_capture_chk #(
  parameter int AddrW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             errValid,
  input logic             regWrEn,
  input logic [1:0]       regSel,
  input logic [15:0]      regWrData,
  input logic             pending,
  input logic [AddrW-1:0] capAddr,
  input logic [15:0]      capStatus,
  input logic             corrEnable,
  input logic             irq
);

  // R3: an error on an armed block is held from the next cycle
  a_r3_capture_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    errValid && !pending |=> pending);

  // R4: an acknowledge with no coincident error leaves nothing held
  a_r4_clear_rearms: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regSel == 2'd1 && !errValid |=> !pending && capStatus == '0);

  // R5: held record is frozen until acknowledged
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rstN)
    pending && !(regWrEn && regSel == 2'd1) |=> $stable(capAddr) && $stable(capStatus));

  // R6: no interrupt without a held error
  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> pending);

  // R2: correction enable follows the written control word
  a_r2_corr_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regSel == 2'd2 |=> corrEnable == $past(regWrData[1]));

endmodule

bind memerr_capture memerr_capture_chk #(.AddrW(AddrW)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .errValid   (errValid),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .regWrData  (regWrData),
  .pending    (pending),
  .capAddr    (capAddr),
  .capStatus  (capStatus),
  .corrEnable (corrEnable),
  .irq        (irq)
);

// File: tb/test_memerr_capture.sv
`timescale 1ns/1ps
module test_memerr_capture;

  logic        clk = 1'b0;
  logic        rstN;
  logic        errValid;
  logic [15:0] errAddr;
  logic [5:0]  errSyndrome;
  logic        errDouble;
  logic [1:0]  errBank;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        corrEnable;
  logic        irq;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural model state
  logic [15:0] mAddr, mStat, mCtrl;
  bit          mPend;

  always #2 clk = ~clk;

  memerr_capture i_memerr_capture (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errAddr(errAddr),
    .errSyndrome(errSyndrome), .errDouble(errDouble), .errBank(errBank),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .corrEnable(corrEnable), .irq(irq)
  );

  function automatic logic [15:0] modelRead(input logic [1:0] s);
    case (s)
      2'd0: return mAddr;
      2'd1: return mStat;
      2'd2: return mCtrl;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit modelIrq();
    if (!mPend) return 0;
    return mStat[9] ? !mCtrl[3] : !mCtrl[2];
  endfunction

  task automatic compare(input string tag);
    logic [15:0] expRd;
    expRd = modelRead(regSel);
    applied++;
    if (regRdData !== expRd) begin
      miscompares++;
      $display("FAIL %s regRdData sel=%0d actual=%h expected=%h", tag, regSel, regRdData, expRd);
    end
    if (irq !== modelIrq()) begin
      miscompares++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, modelIrq());
    end
    if (corrEnable !== mCtrl[1]) begin
      miscompares++;
      $display("FAIL %s corrEnable actual=%b expected=%b", tag, corrEnable, mCtrl[1]);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare after
  task automatic cyc(input bit we, input logic [1:0] sel, input logic [15:0] wd,
                     input bit ev, input logic [15:0] ea, input logic [5:0] es,
                     input bit ed, input logic [1:0] eb, input string tag);
    @(negedge clk);
    regWrEn = we; regSel = sel; regWrData = wd;
    errValid = ev; errAddr = ea; errSyndrome = es; errDouble = ed; errBank = eb;
    @(posedge clk);
    if (we && sel == 2'd1) begin
      mPend = 0; mAddr = 0; mStat = 0;
    end
    if (we && sel == 2'd2) mCtrl = wd;
    if (ev && !mPend) begin
      mPend = 1;
      mAddr = ea;
      mStat = 16'({~es, 2'b00}) | 16'(eb) | (ed ? 16'h0200 : 16'h0000);
    end
    #1;
    compare(tag);
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    cyc(0, sel, 16'h0, 0, 16'h0, 6'h0, 0, 2'h0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d, input string tag);
    cyc(1, sel, d, 0, 16'h0, 6'h0, 0, 2'h0, tag);
  endtask

  task automatic err(input logic [15:0] a, input logic [5:0] s, input bit d,
                     input logic [1:0] b, input string tag);
    cyc(0, 2'd1, 16'h0, 1, a, s, d, b, tag);
  endtask

  task automatic expectRead(input logic [1:0] sel, input logic [15:0] v, input string tag);
    rd(sel, tag);
    applied++;
    if (regRdData !== v) begin
      miscompares++;
      $display("FAIL %s absolute read sel=%0d actual=%h expected=%h", tag, sel, regRdData, v);
    end
  endtask

  task automatic expectIrq(input bit v, input string tag);
    applied++;
    if (irq !== v) begin
      miscompares++;
      $display("FAIL %s absolute irq actual=%b expected=%b", tag, irq, v);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 0; errValid = 0; errAddr = 0; errSyndrome = 0; errDouble = 0; errBank = 0;
    regWrEn = 0; regSel = 0; regWrData = 0;
    mAddr = 0; mStat = 0; mCtrl = 16'hFFFF; mPend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state, R8 each select
    expectRead(2'd0, 16'h0000, "R1 addr");
    expectRead(2'd1, 16'h0000, "R1 status");
    expectRead(2'd2, 16'hFFFF, "R1 ctrl");
    expectRead(2'd3, 16'h0000, "R8 sel3");
    expectIrq(0, "R1 irq");

    // R2 correct and report (octal 177763)
    wr(2'd2, 16'hFFF3, "R2 write ctrl");
    expectRead(2'd2, 16'hFFF3, "R2 readback");

    // R3 single error capture: ~000101 = 111010 -> 0xE8, bank 2 -> 0xEA
    err(16'h1234, 6'b000101, 0, 2'd2, "R3 single");
    expectRead(2'd1, 16'h00EA, "R3 status fields");
    expectRead(2'd0, 16'h1234, "R3 addr");
    expectIrq(1, "R6 single reported");

    // R5 second error ignored
    cyc(0, 2'd0, 16'h0, 1, 16'hBEEF, 6'h3F, 1, 2'd1, "R5 second error");
    expectRead(2'd0, 16'h1234, "R5 addr frozen");
    expectRead(2'd1, 16'h00EA, "R5 status frozen");

    // R9 address and unused writes ignored
    wr(2'd0, 16'h5555, "R9 addr write");
    wr(2'd3, 16'hAAAA, "R9 sel3 write");
    expectRead(2'd0, 16'h1234, "R9 addr unchanged");
    expectRead(2'd2, 16'hFFF3, "R9 ctrl unchanged");

    // R7 control changes irq, R2 corrEnable (177761 clears weight 2)
    wr(2'd2, 16'hFFFF, "R7 silence");
    expectIrq(0, "R7 silenced");
    wr(2'd2, 16'hFFF1, "R7 report no-correct");
    expectIrq(1, "R7 re-raised");
    expectRead(2'd1, 16'h00EA, "R7 record kept");

    // R4 clear
    wr(2'd1, 16'h0000, "R4 clear");
    expectRead(2'd0, 16'h0000, "R4 addr cleared");
    expectIrq(0, "R4 irq dropped");

    // R6 double error with only single reporting (weight 8 set): 0xFFFB
    wr(2'd2, 16'hFFFB, "R6 single-only");
    err(16'h0F0F, 6'b111111, 1, 2'd3, "R6 double");
    expectRead(2'd1, 16'h0203, "R3 double status");
    expectIrq(0, "R6 double not reported");
    wr(2'd2, 16'hFFF7, "R6 double-only");
    expectIrq(1, "R6 double reported");

    // R4 clear with coincident error: captured
    cyc(1, 2'd1, 16'h0, 1, 16'h00AA, 6'b000000, 0, 2'd1, "R4 clear+error");
    expectRead(2'd1, 16'h00FD, "R4 coincident captured");
    expectRead(2'd0, 16'h00AA, "R4 coincident addr");
    expectIrq(0, "R6 single not enabled by FFF7");

    // R6 neither reported (177775)
    wr(2'd2, 16'hFFFD, "R6 neither");
    expectIrq(0, "R6 neither irq");

    // mixed sequence against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], r[3:2], {r[27:20], r[11:4]}, r[12] & r[13],
          r[31:16], r[19:14], r[28], r[30:29], "R3-R9 mixed");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule